// File: doc/BRIEF.md
# Host-side bidirectional printer port controller

This block connects a CPU register bus to a parallel printer cable. The CPU sees three byte-wide registers behind a 3-bit address: a data latch, a read-only status byte and a read/write control byte. Any access counts only while the block's own active-low select is low. Writing the data latch starts an automatic transfer. The latch drives the cable at once, the strobe line falls after a setup time, stays low for a pulse time, and the data is then held for a hold time. All three times are set in nanoseconds and turned into clock counts from the clock frequency parameter.

The five printer status inputs pass through two-flop synchronisers before they reach the status byte. A low-to-high change on the acknowledge input sets an internal print-done flag. Reading the status byte clears that flag. The flag drives the interrupt output when the control byte allows it. The interrupt's output enable also needs an external enable pin, so after reset the interrupt is not driven. The data lines turn around to input only when an external mode pin selects extended mode and the control byte's direction bit is set. Tri-state pads are modelled as output-enable signals.

Top module: `lpt_host_port`

## Requirements
- R1: After reset the control byte reads 0x00, strobe_n, autofeed_n, init_n and select_n are 1, pd_oe is 1, irq and irq_oe are 0, and status bit 2 is 0.
- R2: A write or read with cs_n high changes no register and has no side effect, and rdata is 0x00 whenever cs_n is high.
- R3: Address 2 is the control byte. Reading it returns exactly the last value written there. The outputs follow it as autofeed_n = ~bit1, init_n = ~bit2 and select_n = ~bit3.
- R4: pd_oe is 0 only when mode_ext is 1 and control bit 5 is 1. With pd_oe at 0, reading address 0 returns pd_in. With pd_oe at 1, it returns the data latch. With mode_ext at 0 the port always drives.
- R5: A write to address 0 loads the latch, which appears on pd_out after that edge. strobe_n then stays high for SETUP cycles, low for PULSE cycles, and the port stays busy for HOLD further cycles. SETUP, PULSE and HOLD are each the ceiling of CLK_HZ × time_ns / 1e9, with a minimum of 1.
- R6: A write to address 0 while a transfer is busy, including its last hold cycle, is ignored. pd_out keeps the old byte, and no new strobe is started.
- R7: A rising edge on ack_n sets status bit 2. The flag is visible three clock edges after the input changes. A falling edge on ack_n does not set it.
- R8: A read of address 1 clears status bit 2 and returns the value the bit had before the read. If an acknowledge edge is detected in the same cycle as that read, the bit stays set.
- R9: irq equals status bit 2 AND control bit 4. irq_oe equals control bit 4 AND irq_en_pin.
- R10: Status byte layout: bit7 busy, bit6 ack_n, bit5 paper_end, bit4 online, bit3 fault_n, bit2 print-done flag, bits 1:0 zero. Each input bit changes two clock edges after its pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select for this port |
| addr | input | 3 | Register address (0 data, 1 status, 2 control) |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| mode_ext | input | 1 | 1 = extended (bidirectional) mode, 0 = output-only mode |
| irq_en_pin | input | 1 | External gate for the interrupt output enable |
| pd_in | input | 8 | Data lines as seen from the cable |
| pd_out | output | 8 | Data latch value driven to the cable |
| pd_oe | output | 1 | Data line output enable |
| strobe_n | output | 1 | Active-low data strobe |
| autofeed_n | output | 1 | Active-low autofeed |
| init_n | output | 1 | Active-low printer initialise |
| select_n | output | 1 | Active-low select-in |
| ack_n | input | 1 | Printer acknowledge (active low) |
| busy | input | 1 | Printer busy |
| paper_end | input | 1 | Printer out of paper |
| online | input | 1 | Printer selected/online |
| fault_n | input | 1 | Printer error (active low) |
| irq | output | 1 | Print-done interrupt level |
| irq_oe | output | 1 | Interrupt output enable |

## Verification
Two functions can land in the same clock edge: an acknowledge edge setting the print-done flag, and a CPU status read clearing it. The bench provokes this by raising ack_n exactly two edges before a status read. The read and the synchronised edge detection then meet on one edge. The bench judges the outcome in three steps. The read must return the bit as set. A side-effect-free look straight afterwards must still show the bit set. A second plain read must then clear it.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SETUP,
        SEQ_STROBE,
        SEQ_HOLD
    } seq_state_e;

    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_STAT = 3'd1;
    localparam logic [2:0] ADDR_CTRL = 3'd2;

    localparam int CTL_AUTOFEED = 1;
    localparam int CTL_INIT     = 2;
    localparam int CTL_SELECT   = 3;
    localparam int CTL_IRQ_EN   = 4;
    localparam int CTL_DIR      = 5;

    // ceiling of clk_hz * ns / 1e9, never below one cycle
    function automatic int ns_to_cycles(longint clk_hz, longint ns);
        longint c;
        c = ((clk_hz / 1000) * ns + 999_999) / 1_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int               WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q;
        logic stable_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= RST_VAL[i];
                stable_q <= RST_VAL[i];
            end else begin
                meta_q   <= d[i];
                stable_q <= meta_q;
            end
        end

        assign q[i] = stable_q;
    end

endmodule

// File: rtl/lpt_strobe_seq.sv
module lpt_strobe_seq
    import lpt_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic strobe_n
);

    localparam int MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_C  = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
    localparam int CW     = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    seq_d.state = SEQ_SETUP;
                    seq_d.cnt   = CW'(SETUP_CYC - 1);
                end
            end
            SEQ_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = SEQ_STROBE;
                    seq_d.cnt   = CW'(PULSE_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SEQ_STROBE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = SEQ_HOLD;
                    seq_d.cnt   = CW'(HOLD_CYC - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = SEQ_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d = '{state: SEQ_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active   = (seq_q.state != SEQ_IDLE);
    assign strobe_n = (seq_q.state != SEQ_STROBE);

endmodule

// File: rtl/lpt_host_port.sv
module lpt_host_port
    import lpt_pkg::*;
#(
    parameter longint CLK_HZ   = 125_000_000,
    parameter int     SETUP_NS = 1000,
    parameter int     PULSE_NS = 1000,
    parameter int     HOLD_NS  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       mode_ext,
    input  logic       irq_en_pin,
    input  logic [7:0] pd_in,
    output logic [7:0] pd_out,
    output logic       pd_oe,
    output logic       strobe_n,
    output logic       autofeed_n,
    output logic       init_n,
    output logic       select_n,
    input  logic       ack_n,
    input  logic       busy,
    input  logic       paper_end,
    input  logic       online,
    input  logic       fault_n,
    output logic       irq,
    output logic       irq_oe
);

    localparam int SETUP_CYC = ns_to_cycles(CLK_HZ, longint'(SETUP_NS));
    localparam int PULSE_CYC = ns_to_cycles(CLK_HZ, longint'(PULSE_NS));
    localparam int HOLD_CYC  = ns_to_cycles(CLK_HZ, longint'(HOLD_NS));
    localparam int N_IN      = 5;
    // idle cable levels: ack_n and fault_n high
    localparam logic [N_IN-1:0] IN_RST = 5'b01001;

    typedef struct packed {
        logic [7:0] data;
        logic [7:0] ctrl;
        logic       flag;
        logic       ack_prev;
    } port_t;

    port_t st_d, st_q;

    logic [N_IN-1:0] raw_in, sync_in;
    logic            s_busy, s_ack, s_pe, s_online, s_fault;
    logic            seq_active;
    logic            sel, wr_data, wr_ctrl, stat_rd, ack_rise;
    logic [7:0]      status;

    assign raw_in = {busy, ack_n, paper_end, online, fault_n};

    lpt_sync #(
        .WIDTH  (N_IN),
        .RST_VAL(IN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (sync_in)
    );

    assign {s_busy, s_ack, s_pe, s_online, s_fault} = sync_in;

    lpt_strobe_seq #(
        .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_data),
        .active  (seq_active),
        .strobe_n(strobe_n)
    );

    always_comb begin
        sel      = !cs_n;
        wr_data  = sel && wr_en && (addr == ADDR_DATA) && !seq_active;
        wr_ctrl  = sel && wr_en && (addr == ADDR_CTRL);
        stat_rd  = sel && rd_en && (addr == ADDR_STAT);
        ack_rise = s_ack && !st_q.ack_prev;

        st_d          = st_q;
        st_d.ack_prev = s_ack;
        if (wr_data) st_d.data = wdata;
        if (wr_ctrl) st_d.ctrl = wdata;
        if (ack_rise) begin
            st_d.flag = 1'b1;
        end else if (stat_rd) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{data: 8'h00, ctrl: 8'h00, flag: 1'b0, ack_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign status = {s_busy, s_ack, s_pe, s_online, s_fault, st_q.flag, 2'b00};

    always_comb begin
        rdata = 8'h00;
        if (sel) begin
            unique case (addr)
                ADDR_DATA: rdata = pd_oe ? st_q.data : pd_in;
                ADDR_STAT: rdata = status;
                ADDR_CTRL: rdata = st_q.ctrl;
                default:   rdata = 8'h00;
            endcase
        end
    end

    assign pd_out     = st_q.data;
    assign pd_oe      = !(mode_ext && st_q.ctrl[CTL_DIR]);
    assign autofeed_n = !st_q.ctrl[CTL_AUTOFEED];
    assign init_n     = !st_q.ctrl[CTL_INIT];
    assign select_n   = !st_q.ctrl[CTL_SELECT];
    assign irq        = st_q.flag && st_q.ctrl[CTL_IRQ_EN];
    assign irq_oe     = st_q.ctrl[CTL_IRQ_EN] && irq_en_pin;

    // observation points for the bound checker
    logic [7:0] ctrl_w;
    logic       flag_w;
    assign ctrl_w = st_q.ctrl;
    assign flag_w = st_q.flag;

endmodule

// File: rtl/lpt_host_port_chk.sv
module lpt_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       mode_ext,
    input logic       pd_oe,
    input logic       strobe_n,
    input logic [7:0] pd_out,
    input logic [7:0] ctrl_w,
    input logic       flag_w,
    input logic       ack_rise,
    input logic       stat_rd,
    input logic       irq
);

    AST_CS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(ctrl_w)); // R2

    AST_COMPAT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ext |-> pd_oe); // R4

    AST_DATA_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> $stable(pd_out)); // R5

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n) |=> $stable(pd_out)); // R6

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rise |=> flag_w); // R7

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ack_rise) |=> !flag_w); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_w); // R9

endmodule

bind lpt_host_port lpt_host_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .mode_ext(mode_ext),
    .pd_oe   (pd_oe),
    .strobe_n(strobe_n),
    .pd_out  (pd_out),
    .ctrl_w  (ctrl_w),
    .flag_w  (flag_w),
    .ack_rise(ack_rise),
    .stat_rd (stat_rd),
    .irq     (irq)
);

// File: tb/tb_lpt_host_port.sv
`timescale 1ns/1ps
module tb_lpt_host_port;

    localparam longint CLK_HZ = 125_000_000;
    localparam int     T_NS   = 1000;
    localparam int     CYC    = int'(((CLK_HZ / 1000) * T_NS + 999_999) / 1_000_000);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       mode_ext = 1'b0, irq_en_pin = 1'b0;
    logic [7:0] pd_in = 8'h00;
    logic [7:0] pd_out;
    logic       pd_oe, strobe_n, autofeed_n, init_n, select_n;
    logic       ack_n = 1'b1, busy = 1'b0, paper_end = 1'b0, online = 1'b0, fault_n = 1'b1;
    logic       irq, irq_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lpt_host_port #(.CLK_HZ(CLK_HZ), .SETUP_NS(T_NS), .PULSE_NS(T_NS), .HOLD_NS(T_NS)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .mode_ext(mode_ext), .irq_en_pin(irq_en_pin),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .strobe_n(strobe_n),
        .autofeed_n(autofeed_n), .init_n(init_n), .select_n(select_n), .ack_n(ack_n),
        .busy(busy), .paper_end(paper_end), .online(online), .fault_n(fault_n),
        .irq(irq), .irq_oe(irq_oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic reg_wr(logic [2:0] a, logic [7:0] v);
        cs_n = 1'b0; wr_en = 1'b1; addr = a; wdata = v;
        step();
        cs_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [7:0] v);
        cs_n = 1'b0; rd_en = 1'b1; addr = a;
        #1 v = rdata;
        step();
        cs_n = 1'b1; rd_en = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [7:0] v);
        cs_n = 1'b0; addr = a;
        #1 v = rdata;
        cs_n = 1'b1;
        #1;
    endtask

    function automatic logic [2:0] exp_lines(logic [7:0] c);
        return {~c[1], ~c[2], ~c[3]};
    endfunction

    function automatic logic exp_oe(logic m, logic [7:0] c);
        return !(m && c[5]);
    endfunction

    function automatic logic [7:0] exp_stat(logic f);
        return {busy, ack_n, paper_end, online, fault_n, f, 2'b00};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] c;
        int n, lows;
        void'($urandom(32'h5EED_0042));

        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 strobe_n", strobe_n, 1);
        chk("R1 lines", {autofeed_n, init_n, select_n}, 3'b111);
        chk("R1 pd_oe", pd_oe, 1);
        chk("R1 irq/irq_oe", {irq, irq_oe}, 2'b00);
        peek(3'd2, v); chk("R1 ctrl", v, 8'h00);
        peek(3'd1, v); chk("R1 flag", v[2], 0);

        // R10 status layout and latency
        busy = 1'b1; paper_end = 1'b1; online = 1'b1; fault_n = 1'b0;
        step();
        peek(3'd1, v); chk("R10 one edge old", v, 8'b0100_1000);
        step();
        peek(3'd1, v); chk("R10 two edges new", v, exp_stat(1'b0));
        busy = 1'b0; paper_end = 1'b0; online = 1'b0; fault_n = 1'b1;
        step(); step();
        peek(3'd1, v); chk("R10 back", v, exp_stat(1'b0));

        // R2 deselected write ignored, rdata zero
        reg_wr(3'd2, 8'h0A);
        cs_n = 1'b1; wr_en = 1'b1; addr = 3'd2; wdata = 8'hF5;
        #1 chk("R2 rdata deselected", rdata, 8'h00);
        step();
        wr_en = 1'b0;
        peek(3'd2, v); chk("R2 ctrl kept", v, 8'h0A);

        // R3 R4 R9 random control patterns
        for (int i = 0; i < 40; i++) begin
            c = 8'($urandom);
            mode_ext = 1'($urandom);
            irq_en_pin = 1'($urandom);
            pd_in = 8'($urandom);
            reg_wr(3'd2, c);
            peek(3'd2, v); chk("R3 readback", v, c);
            chk("R3 lines", {autofeed_n, init_n, select_n}, exp_lines(c));
            chk("R4 pd_oe", pd_oe, exp_oe(mode_ext, c));
            chk("R9 irq_oe", irq_oe, c[4] & irq_en_pin);
            chk("R9 irq idle", irq, 0);
            if (!exp_oe(mode_ext, c)) begin
                peek(3'd0, v); chk("R4 input read", v, pd_in);
            end
        end
        mode_ext = 1'b0;
        reg_wr(3'd2, 8'h20);
        chk("R4 compat ignores DIR", pd_oe, 1);

        // R5 R6 strobe sequence
        reg_wr(3'd2, 8'h00);
        reg_wr(3'd0, 8'hA5);
        chk("R5 data out", pd_out, 8'hA5);
        n = 0;
        while (strobe_n && n < 1000) begin
            step();
            n++;
        end
        chk("R5 setup cycles", n, CYC);
        lows = 0;
        while (!strobe_n && lows < 1000) begin
            lows++;
            if (lows == 1) reg_wr(3'd0, 8'h3C); else step();
        end
        chk("R5 pulse cycles", lows, CYC);
        chk("R6 write in strobe ignored", pd_out, 8'hA5);
        for (int k = 0; k < CYC - 1; k++) step();
        reg_wr(3'd0, 8'hC3);
        chk("R6 write in last hold ignored", pd_out, 8'hA5);
        chk("R6 no new strobe", strobe_n, 1);
        reg_wr(3'd0, 8'h5A);
        chk("R5 idle write accepted", pd_out, 8'h5A);
        for (int k = 0; k < 3 * CYC + 4; k++) step();

        // R7 R9 acknowledge edges
        irq_en_pin = 1'b1;
        reg_wr(3'd2, 8'h10);
        chk("R9 irq_oe on", irq_oe, 1);
        ack_n = 1'b0;
        repeat (4) step();
        peek(3'd1, v); chk("R7 fall no flag", v[2], 0);
        ack_n = 1'b1;
        step(); step();
        chk("R7 flag not yet", irq, 0);
        step();
        chk("R7 flag after 3 edges", irq, 1);
        peek(3'd1, v); chk("R7 status bit2", v[2], 1);

        // R8 read clears
        reg_rd(3'd1, v); chk("R8 read returns set", v[2], 1);
        peek(3'd1, v); chk("R8 cleared", v[2], 0);
        chk("R8 irq dropped", irq, 0);

        // R8 coincident set and clear: set wins
        ack_n = 1'b0; repeat (4) step();
        ack_n = 1'b1; repeat (4) step();
        ack_n = 1'b0; repeat (4) step();
        ack_n = 1'b1; step(); step();
        reg_rd(3'd1, v); chk("R8 coincident read value", v[2], 1);
        peek(3'd1, v); chk("R8 set wins", v[2], 1);

        // R9 gating by control bit 4
        reg_wr(3'd2, 8'h00);
        chk("R9 irq masked", irq, 0);
        chk("R9 irq_oe masked", irq_oe, 0);
        reg_rd(3'd1, v);
        peek(3'd1, v); chk("R8 final clear", v[2], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule